// File: doc/BRIEF.md
# Dual-Clock FIFO with Early-Full Reserve

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. Words are held in a circular buffer built on a dual-port memory. The write side tracks a write pointer and the read side tracks a read pointer. Each pointer is one bit wider than the memory address. Each pointer is turned into Gray code and registered. It then passes through delay stages that cover the memory latency in its own domain. After that it goes through a multi-stage synchronizer into the other domain, where it is turned back into binary.

The full indication is raised early. A reserve input sets how many free words must remain, and full rises as soon as the occupancy seen on the write side plus the reserve reaches the depth. A producer that reacts to full only several cycles later can still land its in-flight words in the reserved slots. The memory only refuses a write when it is truly full. Such a write is discarded and recorded in a sticky overflow flag. A read request is served only when the FIFO is not empty, and the served word appears one read-clock cycle later with a valid flag.

Top module: `xclk_fifo`

## Requirements
- R1: After both active-low resets are asserted together and released, rd_empty is 1, wr_full is 0 (for any reserve below the depth), wr_overflow is 0 and rd_valid is 0.
- R2: With a producer that stops writing within a delay no larger than the reserve after wr_full rises, every word is read out exactly once and in write order, and wr_overflow stays 0.
- R3: wr_full is 1 exactly when the write side's view of occupancy (write pointer minus synchronized read pointer) plus the reserve input (width log2 of depth) is at least the depth; it falls again once reads reach the write side.
- R4: A write offered while wr_full is 1 but fewer than depth words are held is stored normally.
- R5: A write offered while the write side sees depth words held is discarded and leaves the stored contents unchanged; it sets wr_overflow, which then stays 1 until reset.
- R6: A read request while rd_empty is 1 yields rd_valid 0 on the next read-clock edge and does not advance the read pointer, so the next word read is still the oldest word.
- R7: A read request while rd_empty is 0 presents the oldest word on rd_data with rd_valid 1 after the next read-clock edge; requests held high on consecutive cycles deliver one word per cycle.
- R8: With two synchronizer stages and one latency stage per side, a word written into an empty FIFO makes rd_empty fall within three write-clock periods plus three read-clock periods after the write edge.
- R9: Each pointer's Gray value, as sent across domains, changes by at most one bit per source-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-domain asynchronous reset, active low |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | DATA_W | Word to store |
| reserve | input | log2(DEPTH) | Free words kept back when raising full, quasi-static |
| wr_full | output | 1 | Early full indication to the producer |
| wr_overflow | output | 1 | Sticky flag: a write was discarded |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-domain asynchronous reset, active low |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Word read out |
| rd_valid | output | 1 | rd_data holds a served word |
| rd_empty | output | 1 | No word available to read |

## Verification
The case that needs the most care is a write arriving on the same write-clock edge at which a newer read pointer reaches the write side. At that moment the full flag and the true-full refusal are both being decided from a pointer that has just changed. This case is provoked by a random stream with a reserve of four and a producer that reacts to wr_full three cycles late. Under that load, full toggles many times while the consumer drains at a random rate. The run is judged by an in-order word-for-word comparison against a queue, together with wr_overflow remaining 0. A directed fill to the exact depth and beyond checks the other edge: writes accepted under an asserted full versus writes refused at true full.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    // Binary to Gray: each output bit is the XOR of a bit and its upper neighbour.
    function automatic logic [31:0] to_gray(input logic [31:0] bin);
        return bin ^ (bin >> 1);
    endfunction

    // Gray to binary: each output bit is the XOR of all Gray bits at or above it.
    function automatic logic [31:0] from_gray(input logic [31:0] gray);
        logic [31:0] bin;
        bin[31] = gray[31];
        for (int i = 30; i >= 0; i--) begin
            bin[i] = bin[i+1] ^ gray[i];
        end
        return bin;
    endfunction

endpackage

// File: rtl/xfifo_pipe.sv
module xfifo_pipe #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic                     wr_clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_clk,
    input  logic                     rd_rst_n,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            rdata_d = store[rd_addr];
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rd_data = rdata_q;

endmodule

// File: rtl/xfifo_wr_ctrl.sv
module xfifo_wr_ctrl
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [$clog2(DEPTH)-1:0] reserve,
    input  logic [$clog2(DEPTH):0]   rgray_sync,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic [$clog2(DEPTH):0]   wgray,
    output logic                     wr_full,
    output logic                     wr_overflow
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          ovf;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [PW-1:0] rbin, occ, level;
    logic          hard_full, accept;

    always_comb begin
        rbin      = PW'(from_gray(32'(rgray_sync)));
        occ       = st_q.ptr - rbin;
        // three-input add: write pointer + inverted read pointer + reserve, plus carry-in
        level     = st_q.ptr + ~rbin + PW'(reserve) + PW'(1);
        hard_full = (occ == DEPTH_P);
        accept    = wr_valid && !hard_full;

        st_d      = st_q;
        st_d.gray = PW'(to_gray(32'(st_q.ptr)));
        if (accept) begin
            st_d.ptr = st_q.ptr + PW'(1);
        end
        if (wr_valid && hard_full) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en       = accept;
    assign wr_addr     = st_q.ptr[AW-1:0];
    assign wgray       = st_q.gray;
    assign wr_full     = level[AW];
    assign wr_overflow = st_q.ovf;

    // R3: full flag matches occupancy plus reserve against depth
    p_full_thresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full == (({1'b0, occ} + {2'b0, reserve}) >= {1'b0, DEPTH_P}));

    // R5: the write side never sees more than depth words held
    p_occ_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_P);

    // R5: overflow flag is sticky
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overflow |=> wr_overflow);

    // R9: transmitted Gray pointer moves by at most one bit per cycle
    p_wgray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_req,
    input  logic [$clog2(DEPTH):0]   wgray_sync,
    output logic                     rd_en,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [$clog2(DEPTH):0]   rgray,
    output logic                     rd_valid,
    output logic                     rd_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          vld;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [PW-1:0] wbin;
    logic          empty, take;

    always_comb begin
        wbin  = PW'(from_gray(32'(wgray_sync)));
        empty = (st_q.ptr == wbin);
        take  = rd_req && !empty;

        st_d      = st_q;
        st_d.gray = PW'(to_gray(32'(st_q.ptr)));
        st_d.vld  = take;
        if (take) begin
            st_d.ptr = st_q.ptr + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en    = take;
    assign rd_addr  = st_q.ptr[AW-1:0];
    assign rgray    = st_q.gray;
    assign rd_valid = st_q.vld;
    assign rd_empty = empty;

    // R6: a request on an empty FIFO yields no valid word
    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_empty) |=> !rd_valid);

    // R7: every served word advanced the read pointer
    p_valid_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (st_q.ptr != $past(st_q.ptr)));

    // R5: read side never sees more than depth words held
    p_rd_occ_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin - st_q.ptr) <= DEPTH_P);

    // R9: transmitted Gray pointer moves by at most one bit per cycle
    p_rgray_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int WR_LAT      = 1,
    parameter int RD_LAT      = 1
) (
    input  logic                     wr_clk,
    input  logic                     wr_rst_n,
    input  logic                     wr_valid,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] reserve,
    output logic                     wr_full,
    output logic                     wr_overflow,
    input  logic                     rd_clk,
    input  logic                     rd_rst_n,
    input  logic                     rd_req,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic                     rd_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] wgray, wgray_dly, wgray_rd;
    logic [PW-1:0] rgray, rgray_dly, rgray_wr;

    xfifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .wr_valid    (wr_valid),
        .reserve     (reserve),
        .rgray_sync  (rgray_wr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wgray       (wgray),
        .wr_full     (wr_full),
        .wr_overflow (wr_overflow)
    );

    xfifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .rd_req     (rd_req),
        .wgray_sync (wgray_rd),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rgray      (rgray),
        .rd_valid   (rd_valid),
        .rd_empty   (rd_empty)
    );

    xfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wr_clk   (wr_clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // memory-latency compensation in the source domain
    if (WR_LAT > 0) begin : g_wlat
        xfifo_pipe #(.W(PW), .STAGES(WR_LAT)) u_wlat (
            .clk (wr_clk), .rst_n (wr_rst_n), .din (wgray), .dout (wgray_dly));
    end else begin : g_wlat_none
        assign wgray_dly = wgray;
    end

    if (RD_LAT > 0) begin : g_rlat
        xfifo_pipe #(.W(PW), .STAGES(RD_LAT)) u_rlat (
            .clk (rd_clk), .rst_n (rd_rst_n), .din (rgray), .dout (rgray_dly));
    end else begin : g_rlat_none
        assign rgray_dly = rgray;
    end

    // synchronizers in the receiving domain
    xfifo_pipe #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk (rd_clk), .rst_n (rd_rst_n), .din (wgray_dly), .dout (wgray_rd));

    xfifo_pipe #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .clk (wr_clk), .rst_n (wr_rst_n), .din (rgray_dly), .dout (rgray_wr));

endmodule

// File: tb/xclk_fifo_tb.sv
`timescale 1ns/1ps
module xclk_fifo_tb_top;

    localparam int DW    = 16;
    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam int WP    = 20;   // 50 MHz write clock
    localparam int RP    = 34;   // unrelated read clock
    localparam int NSTREAM = 400;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          wr_valid = 0, rd_req = 0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] reserve = '0;
    logic          wr_full, wr_overflow, rd_valid, rd_empty;
    logic [DW-1:0] rd_data;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [DW-1:0] exp_q[$];

    always #(WP/2) wr_clk = ~wr_clk;
    always #(RP/2) rd_clk = ~rd_clk;

    xclk_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .reserve(reserve), .wr_full(wr_full), .wr_overflow(wr_overflow),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_empty(rd_empty));

    function automatic logic exp_full(int occ, int rsv);
        return (occ + rsv) >= DEPTH;
    endfunction

    function automatic logic [DW-1:0] pat(int k);
        return DW'(16'h1000 + k * 3);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_valid = 0; rd_req = 0;
        wr_rst_n = 0; rd_rst_n = 0;
        #(5*RP);
        @(negedge wr_clk) wr_rst_n = 1;
        @(negedge rd_clk) rd_rst_n = 1;
        #(4*RP);
    endtask

    task automatic settle();
        #(12*RP);
    endtask

    task automatic write_word(logic [DW-1:0] d);
        @(negedge wr_clk) begin wr_valid = 1; wr_data = d; end
        @(negedge wr_clk) wr_valid = 0;
    endtask

    task automatic read_word(output logic [DW-1:0] d, output logic ok);
        @(negedge rd_clk) rd_req = 1;
        @(negedge rd_clk) rd_req = 0;
        d = rd_data; ok = rd_valid;
    endtask

    initial begin
        #(4_000_000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic ok;
        longint t0, t1;
        void'($urandom(32'd7321));

        // R1: reset state
        reserve = AW'(3);
        do_reset();
        @(negedge rd_clk);
        chk("R1 empty", rd_empty, 1);
        chk("R1 valid", rd_valid, 0);
        chk("R1 full", wr_full, 0);
        chk("R1 overflow", wr_overflow, 0);

        // R6: read on empty, then the first written word is still first
        read_word(d, ok);
        chk("R6 no valid on empty", ok, 0);
        write_word(16'hA5A5);
        settle();
        read_word(d, ok);
        chk("R6 valid after write", ok, 1);
        chk("R6 oldest word", d, 16'hA5A5);
        @(negedge rd_clk);
        chk("R6 empty again", rd_empty, 1);

        // R8: latency bound from write edge to empty falling
        @(negedge wr_clk) begin wr_valid = 1; wr_data = 16'h5A5A; end
        @(posedge wr_clk) t0 = $time;
        @(negedge wr_clk) wr_valid = 0;
        t1 = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge rd_clk);
            if (!rd_empty) begin t1 = $time; break; end
        end
        chk("R8 latency bound", ((t1 != 0) && (t1 - t0 <= 3*WP + 3*RP)), 1);
        read_word(d, ok);
        chk("R2 latency word", d, 16'h5A5A);

        // R3/R4/R5: fill with reserve 5, beyond depth, then drain
        reserve = AW'(5);
        settle();
        for (int k = 1; k <= DEPTH; k++) begin
            write_word(pat(k));
            chk($sformatf("R3 full at occ %0d", k), wr_full, exp_full(k, 5));
        end
        chk("R4 writes under full kept", wr_overflow, 0);
        for (int k = 0; k < 3; k++) write_word(16'hDEAD);
        chk("R5 overflow set", wr_overflow, 1);
        chk("R3 full held", wr_full, 1);
        for (int k = 1; k <= DEPTH; k++) begin
            read_word(d, ok);
            chk($sformatf("R4 word %0d valid", k), ok, 1);
            chk($sformatf("R4 word %0d data", k), d, pat(k));
        end
        read_word(d, ok);
        chk("R5 dropped words not stored", ok, 0);
        settle();
        chk("R3 full released after drain", wr_full, 0);
        chk("R5 overflow sticky", wr_overflow, 1);

        // R1: reset clears overflow
        reserve = '0;
        do_reset();
        chk("R1 overflow cleared", wr_overflow, 0);

        // R7: back-to-back reads
        for (int k = 0; k < 8; k++) write_word(pat(100 + k));
        settle();
        @(negedge rd_clk) rd_req = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge rd_clk);
            chk($sformatf("R7 burst valid %0d", i), rd_valid, 1);
            chk($sformatf("R7 burst data %0d", i), rd_data, pat(100 + i));
            if (i == 7) rd_req = 0;
        end
        chk("R7 empty after burst", rd_empty, 1);

        // R2/R9: random stream with late-reacting producer
        reserve = AW'(4);
        settle();
        fork
            begin : producer
                logic [2:0] hist = '0;
                int sent = 0;
                while (sent < NSTREAM) begin
                    @(negedge wr_clk);
                    wr_valid = 0;
                    if (!hist[2] && ($urandom % 10) < 7) begin
                        wr_valid = 1;
                        wr_data  = DW'($urandom);
                        exp_q.push_back(wr_data);
                        sent++;
                    end
                    hist = {hist[1:0], wr_full};
                end
                @(negedge wr_clk) wr_valid = 0;
            end
            begin : consumer
                int got = 0;
                while (got < NSTREAM) begin
                    @(negedge rd_clk);
                    if (rd_valid) begin
                        logic [DW-1:0] e;
                        e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
                        chk($sformatf("R2/R9 stream word %0d", got), rd_data, e);
                        got++;
                    end
                    rd_req = (($urandom % 10) < 6);
                end
                rd_req = 0;
            end
        join
        chk("R2 no overflow in stream", wr_overflow, 0);
        settle();
        chk("R2 empty at end", rd_empty, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule